// File: doc/BRIEF.md
# Pulse-Width Byte Serializer

This block sends one byte as a train of eight pulse-width coded bit cells on a single modulation line. Every cell opens with an unmodulated interval (line low) and closes with a modulated interval (line high). Both intervals together always last the same cell time. The length of the low interval tells a one from a zero. All durations are counted in microsecond ticks, and a prescaler makes those ticks from the system clock.

A client places a byte on `tx_byte` and pulses `start` while `busy` is low. The block captures the byte and sends bit 0 first. The cells follow one another with no gap. When the last cell ends, the line stays high and `done` pulses for one clock. A `start` that arrives during a transfer has no effect.

Top module: `pw_byte_tx`

## Requirements
- R1: During and after a synchronous reset, `mod_out` is 1 and both `busy` and `done` are 0.
- R2: A bit of value 1 drives `mod_out` low for ONE_LOW_US microseconds and then high for ONE_HIGH_US microseconds. The defaults are 1000 and 1000.
- R3: A bit of value 0 drives `mod_out` low for ZERO_LOW_US microseconds and then high for ZERO_HIGH_US microseconds. The defaults are 300 and 1700.
- R4: Bits are sent least significant first. Cell k carries bit k of the captured byte, where k runs from 0 to 7.
- R5: The eight cells follow one another with no gap. The first low interval starts in the clock cycle right after the cycle in which `start` is sampled with `busy` low.
- R6: `busy` is 1 from the cycle after an accepted `start` until the last cell has ended, and 0 at all other times.
- R7: `done` is 1 for exactly one cycle, the cycle right after the last cell ends. `mod_out` stays 1 from then on until the next transfer.
- R8: A `start` that arrives while `busy` is 1 is ignored. A change on `tx_byte` during a transfer does not change the bits being sent.
- R9: One microsecond equals CLKS_PER_US system clock cycles. An interval of N microseconds therefore lasts N*CLKS_PER_US cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to send `tx_byte` |
| tx_byte | input | 8 | Byte to serialize |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the final cell |
| mod_out | output | 1 | Modulation line (1 = modulated) |

## Verification
The hardest case to reach is a second `start` that lands mid-transfer together with a different `tx_byte`. It only shows up as a fault if the block re-latches the byte or restarts the cell train, and both of those can only be seen later on the line. The stimulus therefore pulses `start` with new data partway through a frame. A cycle-accurate behavioural model then confirms that the rest of the original frame and its `done` timing come out unchanged. Shortened durations and a prescaler above one keep many full frames inside the run, while still testing that each interval lasts a whole multiple of the prescaler.

// File: rtl/pw_pkg.sv
package pw_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_GAP  = 2'd1,
        PH_MARK = 2'd2
    } phase_t;

    typedef struct packed {
        phase_t     phase;
        logic [2:0] bit_idx;
        logic [7:0] data;
    } tx_state_t;

    function automatic logic pick_bit(input logic [7:0] data, input logic [2:0] idx);
        logic [7:0] mask;
        mask = 8'd1 << idx;
        return (data & mask) != 8'd0;
    endfunction

endpackage

// File: rtl/pw_tick_gen.sv
module pw_tick_gen #(
    parameter int CLKS_PER_US = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_US - 1);

    logic [PW-1:0] pre_cnt;

    assign tick = run && (pre_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || tick)
            pre_cnt <= '0;
        else
            pre_cnt <= pre_cnt + 1'b1;
    end

    a_r9_prescale_bound: assert property (@(posedge clk) disable iff (rst)
        pre_cnt <= LAST);
    a_r9_idle_no_tick: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pre_cnt == '0));
endmodule

// File: rtl/pw_interval_timer.sv
module pw_interval_timer #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] us_cnt;

    assign expire = tick && (us_cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run || expire)
            us_cnt <= '0;
        else if (tick)
            us_cnt <= us_cnt + 1'b1;
    end

    a_r9_count_in_range: assert property (@(posedge clk) disable iff (rst)
        run |-> (us_cnt < limit));
endmodule

// File: rtl/pw_byte_tx.sv
module pw_byte_tx
    import pw_pkg::*;
#(
    parameter int CLKS_PER_US  = 2,
    parameter int ONE_LOW_US   = 1000,
    parameter int ONE_HIGH_US  = 1000,
    parameter int ZERO_LOW_US  = 300,
    parameter int ZERO_HIGH_US = 1700
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic       busy,
    output logic       done,
    output logic       mod_out
);
    localparam int MAX_A = (ONE_LOW_US > ZERO_LOW_US) ? ONE_LOW_US : ZERO_LOW_US;
    localparam int MAX_B = (ONE_HIGH_US > ZERO_HIGH_US) ? ONE_HIGH_US : ZERO_HIGH_US;
    localparam int MAX_US = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int UW = $clog2(MAX_US + 1);

    tx_state_t st;
    logic      cur_bit;
    logic      tick;
    logic      expire;
    logic      running;
    logic [UW-1:0] limit;

    assign running = (st.phase != PH_IDLE);
    assign cur_bit = pick_bit(st.data, st.bit_idx);

    always_comb begin
        case (st.phase)
            PH_GAP:  limit = cur_bit ? UW'(ONE_LOW_US)  : UW'(ZERO_LOW_US);
            PH_MARK: limit = cur_bit ? UW'(ONE_HIGH_US) : UW'(ZERO_HIGH_US);
            default: limit = UW'(1);
        endcase
    end

    pw_tick_gen #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
        .clk(clk), .rst(rst), .run(running), .tick(tick)
    );

    pw_interval_timer #(.W(UW)) u_timer (
        .clk(clk), .rst(rst), .run(running), .tick(tick),
        .limit(limit), .expire(expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st.phase   <= PH_IDLE;
            st.bit_idx <= '0;
            st.data    <= '0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st.phase)
                PH_IDLE: if (start) begin
                    st.phase   <= PH_GAP;
                    st.bit_idx <= '0;
                    st.data    <= tx_byte;
                end
                PH_GAP: if (expire) st.phase <= PH_MARK;
                PH_MARK: if (expire) begin
                    if (st.bit_idx == 3'd7) begin
                        st.phase <= PH_IDLE;
                        done     <= 1'b1;
                    end else begin
                        st.phase   <= PH_GAP;
                        st.bit_idx <= st.bit_idx + 1'b1;
                    end
                end
                default: st.phase <= PH_IDLE;
            endcase
        end
    end

    assign busy    = running;
    assign mod_out = (st.phase != PH_GAP);

    a_r5_start_opens_gap: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !mod_out));
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> ($fell(busy) && mod_out));
    a_r8_data_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(st.data));
    a_r4_index_steps: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$stable(st.bit_idx)) |-> (st.bit_idx == $past(st.bit_idx) + 3'd1));
endmodule

// File: tb/sim_pw_byte_tx.sv
module sim_pw_byte_tx;
    localparam int C  = 3;
    localparam int OL = 10, OH = 10, ZL = 3, ZH = 17;
    localparam int CELL = (OL + OH) * C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic busy, done, mod_out;

    int vecs = 0;
    int fails = 0;

    always #2 clk = ~clk;

    pw_byte_tx #(.CLKS_PER_US(C), .ONE_LOW_US(OL), .ONE_HIGH_US(OH),
                 .ZERO_LOW_US(ZL), .ZERO_HIGH_US(ZH)) u0 (
        .clk(clk), .rst(rst), .start(start), .tx_byte(tx_byte),
        .busy(busy), .done(done), .mod_out(mod_out)
    );

    // behavioural reference: queue of expected line levels
    bit exp_q[$];
    bit exp_done = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            exp_q.delete();
            exp_done = 1'b0;
        end else begin
            bit was_empty;
            was_empty = (exp_q.size() == 0);
            if (!was_empty) begin
                void'(exp_q.pop_front());
                exp_done = (exp_q.size() == 0);
            end else begin
                exp_done = 1'b0;
            end
            if (was_empty && start) begin
                for (int i = 0; i < 8; i++) begin
                    int lo, hi;
                    lo = tx_byte[i] ? OL : ZL;
                    hi = tx_byte[i] ? OH : ZH;
                    for (int k = 0; k < lo * C; k++) exp_q.push_back(1'b0);
                    for (int k = 0; k < hi * C; k++) exp_q.push_back(1'b1);
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            bit em, eb;
            em = (exp_q.size() != 0) ? exp_q[0] : 1'b1;
            eb = (exp_q.size() != 0);
            vecs++;
            if (mod_out !== em || busy !== eb || done !== exp_done) begin
                fails++;
                $display("FAIL R2/R3/R4/R5/R6/R7: mod=%b busy=%b done=%b expected mod=%b busy=%b done=%b",
                         mod_out, busy, done, em, eb, exp_done);
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // send a byte, measure cycles to done and first low run
    task automatic send(input logic [7:0] b, input bit stray,
                        output int total, output int first_low);
        int n;
        bit seen_high;
        @(negedge clk);
        tx_byte = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        first_low = 0;
        seen_high = 1'b0;
        while (!done && n < 20000) begin
            if (!mod_out && !seen_high) first_low++;
            if (mod_out && first_low > 0) seen_high = 1'b1;
            if (stray && n == 50) begin
                tx_byte = ~b;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        total = n;
    endtask

    initial begin
        int tot, fl;
        repeat (3) @(negedge clk);
        check("R1 mod_out in reset", int'(mod_out), 1);
        check("R1 busy in reset", int'(busy), 0);
        check("R1 done in reset", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", int'(mod_out), 1);

        send(8'h01, 1'b0, tot, fl);
        check("R2 one-bit low width", fl, OL * C);
        check("R9 frame length 0x01", tot, 7 * (ZL + ZH) * C + (OL + OH) * C + 1);

        send(8'h00, 1'b0, tot, fl);
        check("R3 zero-bit low width", fl, ZL * C);
        check("R5 frame length back-to-back", tot, 8 * CELL + 1);

        send(8'h80, 1'b0, tot, fl);
        check("R4 lsb first (0x80 starts with zero)", fl, ZL * C);

        send(8'hFE, 1'b0, tot, fl);
        check("R4 lsb first (0xFE starts with zero)", fl, ZL * C);

        send(8'hA5, 1'b1, tot, fl);
        check("R8 stray start ignored, frame length", tot, 8 * CELL + 1);
        check("R8 stray start ignored, first low", fl, OL * C);
        @(negedge clk);
        check("R7 line high after done", int'(mod_out), 1);
        check("R6 busy low after done", int'(busy), 0);
        check("R7 done single cycle", int'(done), 0);

        send(8'h3C, 1'b0, tot, fl);
        send(8'hFF, 1'b0, tot, fl);
        check("R2 all ones frame", tot, 8 * (OL + OH) * C + 1);
        repeat (5) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule